// File: doc/BRIEF.md
# Bus-Mapped GPIO and Interrupt Expander

This block is a small register-mapped pin expander of the kind built into a board-level programmable logic device. A host processor reaches it over a simple 16-bit parallel bus. It can read the levels of input pins. It can write latched output pins. It can also read and clear a shared register of pending interrupt events. Registers are either 8 or 16 bits wide. The register index is scaled by the bus width to form the byte address, so registers sit 2 bytes apart on a 16-bit bus and 4 bytes apart on a 32-bit bus.

Every input pin passes through a two-flop synchronizer. A configurable number of the lowest-numbered inputs also act as interrupt sources. A rising edge on one of these synchronized sources sets its pending bit. The bit holds until the host clears it. A single registered interrupt line tells the host that some event is pending. There is no per-source mask in hardware, so masking is done by the host. The host clears events by writing the acknowledge register. A parameter selects whether ones or zeros in the written data do the clearing. After every acknowledge, the interrupt line drops for a cycle. This means events that are still pending, or that arrive at the same moment, show up as a fresh rising edge.

Top module: `gpio_irq_expander`

## Requirements
- R1: The byte address of register index k is k shifted left by 1 when BUS_W=16, or by 2 when BUS_W=32. An address whose low 1 or 2 bits are nonzero selects no register: it reads 0 and a write to it changes nothing.
- R2: Pin n belongs to register IN_BASE + n/REG_W (inputs) or OUT_BASE + n/REG_W (outputs), at bit n mod REG_W of that register.
- R3: Reading an input register returns the pin levels after a two-flop synchronizer, so a pin change is visible on the second rising clock edge. Bits above REG_W, and bits for pins that do not exist, read 0.
- R4: Writing an output register loads all REG_W of its bits at once from bus_wdata. The pins keep that value until the register is written again, and a read returns the latched value, with bits for pins that do not exist reading 0.
- R5: Reset sets pin_out to OUT_INIT, clears every pending bit and drives host_irq low.
- R6: A rising edge on synchronized input pin i, for i below N_IRQ, sets pending bit i on the third rising clock edge after the pin changes. Falling edges set nothing. A pending bit stays set until an acknowledge clears it.
- R7: Reading register ACK_IDX returns pending bit i in data bit i, with zeros above N_IRQ. Reading does not change the pending bits.
- R8: A write to ACK_IDX clears pending bit i when written data bit i equals the clear level. The clear level is 1 when INV_ACK=0 and 0 when INV_ACK=1, so 0xFFFF or 0x0000 respectively clears everything. All other bits are kept.
- R9: If a rising edge arrives in the same cycle as an acknowledge that would clear its bit, the bit stays set.
- R10: host_irq is the OR of all pending bits, registered one clock later, with no masking.
- R11: In the cycle after any acknowledge write, host_irq is low. If bits are still pending, it rises again on the next edge.
- R12: Writes to input registers have no effect on pins, pending bits or read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| pin_in | input | N_IN | Raw input pins |
| pin_out | output | N_OUT | Latched output pins |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
The assertions check several rules on every cycle. A pending bit never drops without an acknowledge write. The interrupt line is low after each acknowledge and tracks the pending set otherwise. The output pins move only on a bus write. Address scaling, the pin-to-bit mapping and the exact latency of synchronizer and pending logic are shown only by the bench scenarios, which include an edge that collides with an acknowledge. The same applies to the inverted acknowledge polarity and to the writes that must be ignored.

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander #(
  parameter int REG_W    = 16,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int N_IN     = 16,
  parameter int N_OUT    = 16,
  parameter int N_IRQ    = 16,
  parameter int IN_BASE  = 0,
  parameter int OUT_BASE = 4,
  parameter int ACK_IDX  = 8,
  parameter bit INV_ACK  = 1'b0,
  parameter logic [N_OUT-1:0] OUT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [N_IN-1:0]   pin_in,
  output logic [N_OUT-1:0]  pin_out,
  output logic              host_irq
);
  localparam int BSH   = (BUS_W == 32) ? 2 : 1;
  localparam int IDX_W = ADDR_W - BSH;
  localparam int NIR   = (N_IN + REG_W - 1) / REG_W;
  localparam int NOR   = (N_OUT + REG_W - 1) / REG_W;

  logic [N_IN-1:0]  sync1, sync2;
  logic [N_IRQ-1:0] sync3, rise, pend_q, clr_mask;
  logic [N_OUT-1:0] out_q;
  logic [IDX_W-1:0] idx;
  logic             aligned, ack_wr;

  assign aligned = (bus_addr[BSH-1:0] == '0);
  assign idx     = bus_addr[ADDR_W-1:BSH];
  assign ack_wr  = bus_we && aligned && (idx == IDX_W'(ACK_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      sync3 <= sync2[N_IRQ-1:0];
    end
  end

  assign rise     = sync2[N_IRQ-1:0] & ~sync3;
  assign clr_mask = INV_ACK ? ~bus_wdata[N_IRQ-1:0] : bus_wdata[N_IRQ-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      host_irq <= 1'b0;
    end else begin
      pend_q   <= (ack_wr ? (pend_q & ~clr_mask) : pend_q) | rise;
      host_irq <= (|pend_q) && !ack_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= OUT_INIT;
    end else if (bus_we && aligned) begin
      for (int b = 0; b < N_OUT; b++) begin
        if (idx == IDX_W'(OUT_BASE + b / REG_W))
          out_q[b] <= bus_wdata[b % REG_W];
      end
    end
  end

  assign pin_out = out_q;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int k = 0; k < NIR; k++) begin
        if (idx == IDX_W'(IN_BASE + k)) begin
          for (int j = 0; j < REG_W; j++) begin
            if (k * REG_W + j < N_IN) bus_rdata[j] = sync2[k * REG_W + j];
          end
        end
      end
      for (int k = 0; k < NOR; k++) begin
        if (idx == IDX_W'(OUT_BASE + k)) begin
          for (int j = 0; j < REG_W; j++) begin
            if (k * REG_W + j < N_OUT) bus_rdata[j] = out_q[k * REG_W + j];
          end
        end
      end
      if (idx == IDX_W'(ACK_IDX)) bus_rdata[N_IRQ-1:0] = pend_q;
    end
  end
endmodule

module gpio_irq_expander_chk #(
  parameter int N_IRQ = 16,
  parameter int N_OUT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             ack_wr,
  input logic [N_IRQ-1:0] pend,
  input logic [N_OUT-1:0] pin_out,
  input logic             host_irq
);
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> ((pend & $past(pend)) == $past(pend))); // R6
  AST_IRQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> !host_irq); // R11
  AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_wr && (pend != '0)) |=> host_irq); // R10
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !host_irq); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_out)); // R4
endmodule

bind gpio_irq_expander gpio_irq_expander_chk #(.N_IRQ(N_IRQ), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .ack_wr(ack_wr),
  .pend(pend_q), .pin_out(pin_out), .host_irq(host_irq)
);

// File: tb/gpio_irq_expander_test.sv
`timescale 1ns/1ps
module gpio_irq_expander_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic [7:0]  a1 = '0;
  logic        we1 = 1'b0;
  logic [15:0] wd1 = '0;
  logic [15:0] rd1;
  logic [11:0] pi1 = '0;
  logic [11:0] po1;
  logic        irq1;

  logic [7:0]  a2 = '0;
  logic        we2 = 1'b0;
  logic [15:0] wd2 = '0;
  logic [15:0] rd2;
  logic [3:0]  pi2 = '0;
  logic [3:0]  po2;
  logic        irq2;

  gpio_irq_expander #(.REG_W(8), .BUS_W(32), .N_IN(12), .N_OUT(12), .N_IRQ(6),
    .INV_ACK(1'b0), .OUT_INIT(12'hA5C)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(a1), .bus_we(we1), .bus_wdata(wd1),
    .bus_rdata(rd1), .pin_in(pi1), .pin_out(po1), .host_irq(irq1));

  gpio_irq_expander #(.REG_W(16), .BUS_W(16), .N_IN(4), .N_OUT(4), .N_IRQ(4),
    .INV_ACK(1'b1), .OUT_INIT(4'h3)) uut_inv (
    .clk(clk), .rst_n(rst_n), .bus_addr(a2), .bus_we(we2), .bus_wdata(wd2),
    .bus_rdata(rd2), .pin_in(pi2), .pin_out(po2), .host_irq(irq2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [7:0] adr, input logic [15:0] d);
    @(negedge clk); a1 = adr; wd1 = d; we1 = 1'b1;
    @(negedge clk); we1 = 1'b0;
  endtask

  task automatic rd1_chk(input string req, input logic [7:0] adr, input logic [15:0] exp);
    a1 = adr; #0.1;
    chk(req, rd1, exp);
  endtask

  task automatic wr2(input logic [7:0] adr, input logic [15:0] d);
    @(negedge clk); a2 = adr; wd2 = d; we2 = 1'b1;
    @(negedge clk); we2 = 1'b0;
  endtask

  task automatic t_reset;
    chk("R5 pin_out", po1, 12'hA5C);
    chk("R5 irq", irq1, 0);
    rd1_chk("R5 pending", 8'd32, 16'h0);
    rd1_chk("R2 out reg0", 8'd16, 16'h005C);
    rd1_chk("R2 out reg1", 8'd20, 16'h000A);
    chk("R5 inv pin_out", po2, 4'h3);
  endtask

  task automatic t_outputs;
    wr1(8'd20, 16'hFFFF);
    chk("R4 whole reg write", po1, 12'hF5C);
    rd1_chk("R4 readback masked", 8'd20, 16'h000F);
    wr1(8'd16, 16'h1234);
    chk("R4 low reg write", po1, 12'hF34);
    repeat (3) @(negedge clk);
    chk("R4 hold", po1, 12'hF34);
    wr1(8'd17, 16'h0000);
    chk("R1 misaligned write ignored", po1, 12'hF34);
    rd1_chk("R1 misaligned read", 8'd17, 16'h0);
    wr2(8'd8, 16'h000A);
    chk("R1 16-bit stride output", po2, 4'hA);
    a2 = 8'd9; #0.1;
    chk("R1 16-bit misaligned read", rd2, 16'h0);
  endtask

  task automatic t_inputs;
    @(negedge clk); pi1 = 12'h9A3;
    @(negedge clk);
    rd1_chk("R3 not yet visible", 8'd0, 16'h0);
    @(negedge clk);
    rd1_chk("R3 input reg0", 8'd0, 16'h00A3);
    rd1_chk("R2 input reg1", 8'd4, 16'h0009);
    @(negedge clk);
    rd1_chk("R6 pending from rises", 8'd32, 16'h0023);
    chk("R10 irq lags pending", irq1, 0);
    @(negedge clk);
    chk("R10 irq high", irq1, 1);
    rd1_chk("R7 read does not clear", 8'd32, 16'h0023);
    wr1(8'd0, 16'h00FF);
    rd1_chk("R12 input write ignored", 8'd0, 16'h00A3);
    rd1_chk("R12 pending unchanged", 8'd32, 16'h0023);
    chk("R12 pins unchanged", po1, 12'hF34);
  endtask

  task automatic t_ack;
    wr1(8'd32, 16'h0002);
    rd1_chk("R8 partial clear", 8'd32, 16'h0021);
    chk("R11 irq low after ack", irq1, 0);
    @(negedge clk);
    chk("R11 irq rises again", irq1, 1);
    wr1(8'd32, 16'hFFFF);
    rd1_chk("R8 clear all", 8'd32, 16'h0);
    @(negedge clk); pi1 = 12'h000;
    repeat (4) @(negedge clk);
    rd1_chk("R6 falling edge ignored", 8'd32, 16'h0);
    chk("R10 irq idle", irq1, 0);
  endtask

  task automatic t_collide;
    @(negedge clk); pi1 = 12'h002;
    repeat (4) @(negedge clk);
    rd1_chk("R6 bit1 set", 8'd32, 16'h0002);
    pi1 = 12'h003;
    @(negedge clk);
    @(negedge clk); a1 = 8'd32; wd1 = 16'hFFFF; we1 = 1'b1;
    @(negedge clk); we1 = 1'b0;
    rd1_chk("R9 edge wins over ack", 8'd32, 16'h0001);
    chk("R11 irq low on collision", irq1, 0);
    @(negedge clk);
    chk("R11 fresh edge after collision", irq1, 1);
  endtask

  task automatic t_inverted;
    @(negedge clk); pi2 = 4'hF;
    repeat (4) @(negedge clk);
    a2 = 8'd16; #0.1;
    chk("R6 inv pending", rd2, 16'h000F);
    wr2(8'd16, 16'hFFFF);
    a2 = 8'd16; #0.1;
    chk("R8 ones do not clear when inverted", rd2, 16'h000F);
    wr2(8'd16, 16'hFFF5);
    a2 = 8'd16; #0.1;
    chk("R8 zeros clear when inverted", rd2, 16'h0005);
    wr2(8'd16, 16'h0000);
    a2 = 8'd16; #0.1;
    chk("R8 inverted clear all", rd2, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_inputs();
    t_ack();
    t_collide();
    t_inverted();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule